// File: doc/BRIEF.md
# DMA Request Burst Limiter

This block drives the DMA request line of a parallel-port FIFO. The request is raised only while DMA is switched on and service interrupts are clear. It asks to fill the FIFO in the write direction and to empty it in the read direction. It is held back whenever the FIFO cannot take part in the next transfer.

Each falling edge of the active-low acknowledge counts as one DMA cycle. That edge also produces a one-clock read or write strobe toward the FIFO, so no address decode is involved. Once a burst of back-to-back granted cycles reaches its cap, the request is forced low. It stays low until acknowledge has been inactive for a minimum time, which leaves the system bus free for refresh.

A terminal-count strobe ends the transfer and produces a one-clock event for the interrupt logic. The request is then withheld until software sets the service-interrupt bit.

Top module: `dma_burst_limiter`

## Requirements
- R1: `dreq_o` is 1 only while `dma_en_i` is 1 and `svc_intr_i` is 0. Setting `svc_intr_i` or clearing `dma_en_i` drops `dreq_o` in the same cycle, with no clock edge needed.
- R2: With `dir_i` = 0 (fill FIFO), `dreq_o` is 0 while `fifo_full_i` is 1. With `dir_i` = 1 (empty FIFO), `dreq_o` is 0 while `fifo_empty_i` is 1. The other flag has no effect in each direction.
- R3: The sampled high-to-low change of `dack_ni` is the only thing that selects a FIFO access.
- R4: For each such change, exactly one of `fifo_wr_o` (when `dir_i` = 0) or `fifo_rd_o` (when `dir_i` = 1) is 1 for one clock, in the cycle after the edge where `dack_ni` is first sampled low. The two strobes are never 1 together.
- R5: `dreq_o` stays 1 through 31 consecutive granted cycles. It drops in the same cycle that the 32nd falling edge of `dack_ni` is presented.
- R6: After the cap, `dreq_o` stays 0 until `dack_ni` has been sampled high on HOLD_CYC consecutive clock edges. HOLD_CYC is the 350 ns hold-off rounded up to whole clock periods, plus one cycle of margin; this is 36 at a 10 ns clock. `dreq_o` returns in the cycle after the last of those edges.
- R7: Sampling `dack_ni` low during the hold-off restarts the idle count from zero.
- R8: The burst count clears whenever the request is withheld for a reason other than the cap. Such reasons are a FIFO flag, a TC, `svc_intr_i`, or `dma_en_i`. A new run of 32 granted cycles is allowed after any of them.
- R9: A 1 on `tc_i` while DMA is active drops `dreq_o` in the same cycle and gives a one-clock `tc_event_o` on the next cycle. `dreq_o` then stays 0 until `svc_intr_i` has been seen at 1. A 1 on `tc_i` while DMA is inactive gives no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | DMA enable |
| svc_intr_i | input | 1 | Service-interrupt bit; 1 blocks requests |
| dir_i | input | 1 | 0 = fill FIFO from memory, 1 = empty FIFO to memory |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_empty_i | input | 1 | FIFO empty flag |
| dack_ni | input | 1 | DMA acknowledge, active low, synchronous to clk_i |
| tc_i | input | 1 | Terminal-count strobe |
| dreq_o | output | 1 | DMA request |
| fifo_wr_o | output | 1 | One-clock FIFO write strobe |
| fifo_rd_o | output | 1 | One-clock FIFO read strobe |
| tc_event_o | output | 1 | One-clock terminal-count event for interrupt logic |

## Verification
The bench checks the cap at its exact boundary. A design with an off-by-one count would either drop the request after the 31st cycle or let a 33rd cycle through. The hold-off is also checked at its exact end: the request must still be low one cycle before the window closes and high right after it. A glitch of acknowledge partway through the hold-off must restart the window, or the request would return too early. A FIFO stall in the middle of a burst must clear the count; if it does not, the next burst is cut short. After a terminal count, the request must stay low until the service bit is seen, and must not reappear in the gap before software reacts.

// File: rtl/dbl_pkg.sv
`timescale 1ns/1ps
package dbl_pkg;
  localparam logic DIR_FILL  = 1'b0;
  localparam logic DIR_DRAIN = 1'b1;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/dbl_ack_edge.sv
`timescale 1ns/1ps
module dbl_ack_edge
  import dbl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dack_ni,
  input  logic dir_i,
  output logic ack_fall_o,
  output logic fifo_wr_o,
  output logic fifo_rd_o
);
  logic dack_q;
  logic wr_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dack_q <= 1'b1;
    else         dack_q <= dack_ni;
  end

  assign ack_fall_o = dack_q & ~dack_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= ack_fall_o & (dir_i == DIR_FILL);
      rd_q <= ack_fall_o & (dir_i == DIR_DRAIN);
    end
  end

  assign fifo_wr_o = wr_q;
  assign fifo_rd_o = rd_q;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_wr_o && fifo_rd_o)); // R4
  AST_WR_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |=> !fifo_wr_o); // R4
  AST_RD_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |=> !fifo_rd_o); // R4
  AST_STROBE_FROM_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o || fifo_rd_o) |-> !$past(dack_ni)); // R3
endmodule

// File: rtl/dbl_req_gate.sv
`timescale 1ns/1ps
module dbl_req_gate
  import dbl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_en_i,
  input  logic svc_intr_i,
  input  logic dir_i,
  input  logic fifo_full_i,
  input  logic fifo_empty_i,
  input  logic tc_i,
  output logic allow_o,
  output logic tc_event_o
);
  logic active;
  logic fifo_stall;
  logic tc_blk_q;
  logic tc_ev_q;

  assign active     = dma_en_i & ~svc_intr_i;
  assign fifo_stall = (dir_i == DIR_FILL) ? fifo_full_i : fifo_empty_i;

  // TC blocks requests until software acknowledges via the service bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tc_blk_q <= 1'b0;
    else if (!active)    tc_blk_q <= 1'b0;
    else if (tc_i)       tc_blk_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tc_ev_q <= 1'b0;
    else         tc_ev_q <= tc_i & active;
  end

  assign allow_o    = active & ~fifo_stall & ~tc_blk_q & ~tc_i;
  assign tc_event_o = tc_ev_q;

  AST_TC_EVENT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_event_o |-> $past(tc_i) && $past(dma_en_i) && !$past(svc_intr_i)); // R9
  AST_TC_EVENT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_event_o && !tc_i) |=> !tc_event_o); // R9
  AST_TC_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && dma_en_i && !svc_intr_i) |=> (!allow_o || !dma_en_i || svc_intr_i) ); // R9
endmodule

// File: rtl/dbl_burst_ctrl.sv
`timescale 1ns/1ps
module dbl_burst_ctrl
  import dbl_pkg::*;
#(
  parameter int unsigned BURST_MAX = 32,
  parameter int unsigned HOLD_CYC  = 36
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dack_ni,
  input  logic ack_fall_i,
  input  logic allow_i,
  output logic hold_o,
  output logic last_grant_o
);
  localparam int unsigned CNT_W  = cnt_width(BURST_MAX);
  localparam int unsigned IDLE_W = cnt_width(HOLD_CYC);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(BURST_MAX - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0]  burst_q;
  logic [IDLE_W-1:0] idle_q;
  logic              hold_q;
  logic              idle_done;

  assign last_grant_o = ~hold_q & ack_fall_i & (burst_q == CNT_LAST);
  assign idle_done    = hold_q & dack_ni & (idle_q == IDLE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= '0;
    end else if (hold_q) begin
      if (idle_done) burst_q <= '0;
    end else if (last_grant_o) begin
      burst_q <= '0;
    end else if (!allow_i) begin
      burst_q <= '0;
    end else if (ack_fall_i) begin
      burst_q <= burst_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           hold_q <= 1'b0;
    else if (last_grant_o) hold_q <= 1'b1;
    else if (idle_done)    hold_q <= 1'b0;
  end

  // consecutive idle-acknowledge cycles while held off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idle_q <= '0;
    else if (!hold_q || !dack_ni) idle_q <= '0;
    else if (!idle_done)        idle_q <= idle_q + 1'b1;
  end

  assign hold_o = hold_q;

  AST_BURST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_q < CNT_W'(BURST_MAX)); // R5
  AST_HOLD_EXIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> $past(dack_ni) && ($past(idle_q) == IDLE_LAST)); // R6
  AST_ACK_RESTARTS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !dack_ni) |=> (idle_q == '0)); // R7
  AST_STALL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && !allow_i) |=> (burst_q == '0)); // R8
endmodule

// File: rtl/dma_burst_limiter.sv
`timescale 1ns/1ps
module dma_burst_limiter
  import dbl_pkg::*;
#(
  parameter int unsigned BURST_MAX     = 32,
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned HOLD_NS       = 350,
  parameter int unsigned MARGIN_CYC    = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_en_i,
  input  logic svc_intr_i,
  input  logic dir_i,
  input  logic fifo_full_i,
  input  logic fifo_empty_i,
  input  logic dack_ni,
  input  logic tc_i,
  output logic dreq_o,
  output logic fifo_wr_o,
  output logic fifo_rd_o,
  output logic tc_event_o
);
  localparam int unsigned HOLD_CYC = ceil_div(HOLD_NS * 1000, CLK_PERIOD_PS) + MARGIN_CYC;

  logic ack_fall;
  logic allow;
  logic hold;
  logic last_grant;

  dbl_ack_edge u_ack_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dack_ni    (dack_ni),
    .dir_i      (dir_i),
    .ack_fall_o (ack_fall),
    .fifo_wr_o  (fifo_wr_o),
    .fifo_rd_o  (fifo_rd_o)
  );

  dbl_req_gate u_req_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dma_en_i     (dma_en_i),
    .svc_intr_i   (svc_intr_i),
    .dir_i        (dir_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_empty_i (fifo_empty_i),
    .tc_i         (tc_i),
    .allow_o      (allow),
    .tc_event_o   (tc_event_o)
  );

  dbl_burst_ctrl #(
    .BURST_MAX (BURST_MAX),
    .HOLD_CYC  (HOLD_CYC)
  ) u_burst_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dack_ni      (dack_ni),
    .ack_fall_i   (ack_fall),
    .allow_i      (allow),
    .hold_o       (hold),
    .last_grant_o (last_grant)
  );

  assign dreq_o = allow & ~hold & ~last_grant;

  AST_REQ_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |-> (dma_en_i && !svc_intr_i)); // R1
  AST_REQ_FIFO_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |-> ((dir_i == DIR_FILL) ? !fifo_full_i : !fifo_empty_i)); // R2
  AST_HOLD_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |-> !dreq_o); // R6
endmodule

// File: tb/sim_dma_burst_limiter.sv
`timescale 1ns/1ps
module sim_dma_burst_limiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_en = 1'b0, svc = 1'b0, dir = 1'b0, full = 1'b0, empty = 1'b0;
  logic dack_n = 1'b1, tc = 1'b0;
  logic dreq, wr, rd, tc_ev;
  int checks = 0;
  int errors = 0;
  localparam int HOLD = 36;

  always #5 clk = ~clk;

  dma_burst_limiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .dma_en_i(dma_en), .svc_intr_i(svc), .dir_i(dir),
    .fifo_full_i(full), .fifo_empty_i(empty), .dack_ni(dack_n), .tc_i(tc),
    .dreq_o(dreq), .fifo_wr_o(wr), .fifo_rd_o(rd), .tc_event_o(tc_ev)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  task automatic ack_cycle();
    @(negedge clk) dack_n = 1'b0;
    @(negedge clk);
    @(negedge clk) dack_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_release();
    dack_n = 1'b1;
    repeat (HOLD + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset dreq", dreq, 1'b0);
    chk("R4 reset wr", wr, 1'b0);
    chk("R4 reset rd", rd, 1'b0);
    chk("R9 reset tc_ev", tc_ev, 1'b0);
  endtask

  task automatic t_gating();
    @(negedge clk) begin dma_en = 1; svc = 0; end
    #1 chk("R1 enabled", dreq, 1'b1);
    svc = 1; #1 chk("R1 svc drops at once", dreq, 1'b0);
    svc = 0; #1 chk("R1 svc cleared", dreq, 1'b1);
    dma_en = 0; #1 chk("R1 disable drops at once", dreq, 1'b0);
    dma_en = 1; #1 chk("R1 re-enable", dreq, 1'b1);
  endtask

  task automatic t_fifo();
    @(negedge clk) begin dir = 0; full = 1; end
    #1 chk("R2 fill while full", dreq, 1'b0);
    full = 0; empty = 1; #1 chk("R2 fill ignores empty", dreq, 1'b1);
    dir = 1; #1 chk("R2 drain while empty", dreq, 1'b0);
    empty = 0; full = 1; #1 chk("R2 drain ignores full", dreq, 1'b1);
    full = 0;
  endtask

  task automatic t_strobe();
    @(negedge clk) begin dir = 0; dack_n = 0; end
    nxt(); chk("R4 wr strobe", wr, 1'b1); chk("R4 no rd in fill", rd, 1'b0);
    nxt(); chk("R4 wr one clock", wr, 1'b0); chk("R3 held ack no repeat", rd, 1'b0);
    @(negedge clk) begin dack_n = 1; dir = 1; end
    @(negedge clk) dack_n = 0;
    nxt(); chk("R4 rd strobe", rd, 1'b1); chk("R4 no wr in drain", wr, 1'b0);
    nxt(); chk("R4 rd one clock", rd, 1'b0);
    @(negedge clk) begin dack_n = 1; dir = 0; end
    // dir flips with no ack: no strobe
    nxt(); chk("R3 no strobe without ack", wr | rd, 1'b0);
    full = 1; nxt(); full = 0; // clear burst count
  endtask

  task automatic t_cap();
    for (int i = 0; i < 31; i++) ack_cycle();
    #1 chk("R5 request after 31", dreq, 1'b1);
    @(negedge clk) dack_n = 0;
    #1 chk("R5 drop on 32nd", dreq, 1'b0);
    @(negedge clk);
    #1 chk("R5 stays low", dreq, 1'b0);
    @(negedge clk) dack_n = 1;
    repeat (HOLD - 1) @(negedge clk);
    #1 chk("R6 still held before window ends", dreq, 1'b0);
    @(negedge clk);
    #1 chk("R6 released after window", dreq, 1'b1);
  endtask

  task automatic t_glitch();
    full = 1; nxt(); full = 0;
    for (int i = 0; i < 32; i++) ack_cycle();
    repeat (20) @(negedge clk);
    dack_n = 0;
    @(negedge clk) dack_n = 1;
    repeat (HOLD - 1) @(negedge clk);
    #1 chk("R7 window restarted by ack", dreq, 1'b0);
    @(negedge clk);
    #1 chk("R7 release after fresh window", dreq, 1'b1);
  endtask

  task automatic t_stall_clears();
    full = 1; nxt(); full = 0;
    for (int i = 0; i < 20; i++) ack_cycle();
    @(negedge clk) full = 1;
    @(negedge clk) full = 0;
    for (int i = 0; i < 31; i++) ack_cycle();
    #1 chk("R8 count cleared by stall", dreq, 1'b1);
    @(negedge clk) dack_n = 0;
    #1 chk("R8 cap after fresh 32", dreq, 1'b0);
    @(negedge clk);
    wait_release();
    #1 chk("R8 restored", dreq, 1'b1);
  endtask

  task automatic t_tc();
    @(negedge clk) tc = 1;
    #1 chk("R9 tc drops at once", dreq, 1'b0);
    @(negedge clk) tc = 0;
    #1 chk("R9 tc event", tc_ev, 1'b1);
    chk("R9 blocked after tc", dreq, 1'b0);
    nxt(); chk("R9 event one clock", tc_ev, 1'b0);
    chk("R9 still blocked", dreq, 1'b0);
    @(negedge clk) svc = 1;
    @(negedge clk) svc = 0;
    #1 chk("R9 released after svc", dreq, 1'b1);
    @(negedge clk) begin dma_en = 0; tc = 1; end
    @(negedge clk) tc = 0;
    #1 chk("R9 no event when inactive", tc_ev, 1'b0);
    dma_en = 1;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_gating();
    t_fifo();
    t_strobe();
    t_cap();
    t_glitch();
    t_stall_clears();
    t_tc();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule